// File: doc/BRIEF.md
# Segmented Boot Image Download Sequencer

This block sits on the host side of a slave memory port and pushes a prepared boot image into it without processor help. The image lives in an internal read-only word array, fixed by a parameter, and is a chain of segment records. A record opens with a word count. The next word is a 15-bit destination address, where bit 14 selects the data memory space and a clear bit 14 selects program memory. The payload words follow. A 24-bit program word uses two payload words and so counts as two.

Each non-empty record produces one write to the address-latch target, followed by one write to the data target for each payload word. The slave raises a busy flag while it cannot take an access. The sequencer holds every access, address and data alike, until that flag is low. A count word equal to 0xFFFF ends the image. A pulse on `start` runs the whole download from array index 0. Image builders put program segments from address 1 upward and leave the segment that holds the restart vector at program address 0 for last. The slave therefore sees that vector only after everything else has arrived.

Top module: `boot_download_seq`

## Requirements
- R1: While reset is active and after it ends, the block issues no write and holds `done` and `error` low until `start` is seen.
- R2: A `start` pulse while idle, done or in error begins reading at array index 0, and the first write of a run is an address-latch write (`wr_sel` = 1).
- R3: The word that follows each non-zero count is written once with `wr_sel` = 1, with its value unchanged, bit 14 included.
- R4: The next `count` array words after the address are written in array order with `wr_sel` = 0. The word after them is then read as the next count.
- R5: A count of 0 is an empty segment: its address word is skipped and no write of any kind is issued for it.
- R6: A count of 0xFFFF stops the run. `done` rises, stays high, and no write occurs until the next `start`.
- R7: No write is issued in a cycle where `slv_busy` is high. The pending word waits and goes out unchanged once busy falls.
- R8: If the array index passes the last array entry before a 0xFFFF count is found, `error` rises and stays high, writing stops and `done` stays low.
- R9: `start` while `done` or `error` is high clears that flag within one cycle and repeats the download from index 0.
- R10: A `start` pulse while a download is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse to begin a download from index 0 |
| slv_busy | input | 1 | Slave busy flag; high blocks any write |
| wr_en | output | 1 | Write strobe toward the slave port |
| wr_sel | output | 1 | Write target: 1 = address latch, 0 = data |
| wr_data | output | 16 | Address or data word being written |
| done | output | 1 | Terminator reached, held until next start |
| error | output | 1 | Image overran the array without terminator, held until next start |

## Verification
The bench builds two copies. The first holds a 14-word image with two program-memory payload words, an empty segment, a data-space segment and a final restart-vector segment at address 0 that ends in 0xFFFF. It exercises every state, including the empty record and busy stalls on both address and data writes. The second copy is built with a 5-word array that has no terminator, so the overrun path ends in the error state after a full segment has been written.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DATA  = 3'd3,
    ST_DONE  = 3'd4,
    ST_ERR   = 3'd5
  } seq_state_t;

  localparam logic [15:0] TERM_WORD = 16'hFFFF;
endpackage

// File: rtl/boot_image_rom.sv
module boot_image_rom #(
  parameter int DW    = 16,
  parameter int DEPTH = 14,
  parameter int IW    = $clog2(DEPTH + 1),
  parameter logic [DEPTH*DW-1:0] IMAGE = '0
) (
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  localparam int SLOTS = 2 ** IW;

  logic [DW-1:0] words [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < DEPTH) begin : g_used
      assign words[g] = IMAGE[g*DW +: DW];
    end else begin : g_pad
      assign words[g] = '0;
    end
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 14,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          slv_busy,
  input  logic [DW-1:0] rom_word,
  output logic [IW-1:0] rom_idx,
  output logic          wr_en,
  output logic          wr_sel,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          error
);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH);

  seq_state_t    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          idx_en, cnt_en;
  logic          past_end;

  assign past_end = (idx_q >= LAST_IDX);
  assign rom_idx  = idx_q;
  assign wr_data  = rom_word;
  assign done     = (state_q == ST_DONE);
  assign error    = (state_q == ST_ERR);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    idx_en  = 1'b0;
    cnt_en  = 1'b0;
    wr_en   = 1'b0;
    wr_sel  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start) begin
          state_d = ST_COUNT;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_COUNT: begin
        if (past_end) begin
          state_d = ST_ERR;
        end else if (rom_word == TERM_WORD) begin
          state_d = ST_DONE;
        end else begin
          cnt_d   = rom_word;
          cnt_en  = 1'b1;
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (past_end) begin
          state_d = ST_ERR;
        end else if (cnt_q == '0) begin
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
          state_d = ST_COUNT;
        end else if (!slv_busy) begin
          wr_en   = 1'b1;
          wr_sel  = 1'b1;
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (past_end) begin
          state_d = ST_ERR;
        end else if (!slv_busy) begin
          wr_en  = 1'b1;
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
          if (cnt_q == DW'(1)) state_d = ST_COUNT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    slv_busy |-> !wr_en); // R7

  AST_BUSY_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && slv_busy && !past_end) |=> $stable(idx_q)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R6

  AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en); // R6

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> (error && !wr_en)); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error})); // R8

  AST_RUN_BEGINS_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(state_q) == ST_COUNT) |-> wr_sel); // R3
endmodule

// File: rtl/boot_download_seq.sv
module boot_download_seq #(
  parameter int DW    = 16,
  parameter int DEPTH = 14,
  parameter logic [DEPTH*DW-1:0] IMAGE = {
    16'hFFFF, 16'h00CC, 16'h3210, 16'h0000, 16'h0002,
    16'hBEEF, 16'h4010, 16'h0001, 16'h0007, 16'h0000,
    16'h0056, 16'h1234, 16'h0001, 16'h0002 }
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          slv_busy,
  output logic          wr_en,
  output logic          wr_sel,
  output logic [15:0]   wr_data,
  output logic          done,
  output logic          error
);
  localparam int IW = $clog2(DEPTH + 1);

  logic          rst_meta, rst_sync;
  logic [IW-1:0] rom_idx;
  logic [DW-1:0] rom_word;
  logic [DW-1:0] wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  boot_image_rom #(.DW(DW), .DEPTH(DEPTH), .IW(IW), .IMAGE(IMAGE)) u_rom (
    .rd_idx  (rom_idx),
    .rd_word (rom_word)
  );

  boot_seq_ctrl #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .start    (start),
    .slv_busy (slv_busy),
    .rom_word (rom_word),
    .rom_idx  (rom_idx),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_word),
    .done     (done),
    .error    (error)
  );

  assign wr_data = 16'(wr_word);
endmodule

// File: tb/test_boot_download_seq.sv
module test_boot_download_seq;
  localparam int DA = 14;
  localparam int DB = 5;
  localparam logic [DA*16-1:0] IMG_A = {
    16'hFFFF, 16'h00CC, 16'h3210, 16'h0000, 16'h0002,
    16'hBEEF, 16'h4010, 16'h0001, 16'h0007, 16'h0000,
    16'h0056, 16'h1234, 16'h0001, 16'h0002 };
  localparam logic [DB*16-1:0] IMG_B = {
    16'h0001, 16'h2222, 16'h1111, 16'h4000, 16'h0002 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic busy_a = 1'b0, busy_b = 1'b0;
  logic wr_en_a, wr_sel_a, done_a, err_a;
  logic wr_en_b, wr_sel_b, done_b, err_b;
  logic [15:0] wr_data_a, wr_data_b;

  int checks = 0;
  int errors = 0;
  logic [16:0] exp_a[$];
  logic [16:0] exp_b[$];
  bit first_a = 1'b0, first_b = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit rand_busy = 1'b0;

  always #4 clk = ~clk;

  boot_download_seq #(.DEPTH(DA), .IMAGE(IMG_A)) i_boot_download_seq (
    .clk(clk), .rst_n(rst_n), .start(start_a), .slv_busy(busy_a),
    .wr_en(wr_en_a), .wr_sel(wr_sel_a), .wr_data(wr_data_a),
    .done(done_a), .error(err_a));

  boot_download_seq #(.DEPTH(DB), .IMAGE(IMG_B)) i_boot_download_seq_ovr (
    .clk(clk), .rst_n(rst_n), .start(start_b), .slv_busy(busy_b),
    .wr_en(wr_en_b), .wr_sel(wr_sel_b), .wr_data(wr_data_b),
    .done(done_b), .error(err_b));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input bit b, input int i);
    return b ? IMG_B[i*16 +: 16] : IMG_A[i*16 +: 16];
  endfunction

  task automatic build(input bit b);
    int d = b ? DB : DA;
    int p = 0;
    int c;
    if (b) exp_b.delete(); else exp_a.delete();
    forever begin
      if (p >= d) return;
      c = int'(word_of(b, p));
      if (c == 16'hFFFF) return;
      p++;
      if (p >= d) return;
      if (c != 0) begin
        if (b) exp_b.push_back({1'b1, word_of(b, p)});
        else   exp_a.push_back({1'b1, word_of(b, p)});
      end
      p++;
      for (int k = 0; k < c; k++) begin
        if (p >= d) return;
        if (b) exp_b.push_back({1'b0, word_of(b, p)});
        else   exp_a.push_back({1'b0, word_of(b, p)});
        p++;
      end
    end
  endtask

  // Reference comparison on every clock, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_a) check(!wr_en_a, "R7", "write while busy (A)", wr_en_a, 0);
      if (done_a || err_a) check(!wr_en_a, "R6", "write after stop (A)", wr_en_a, 0);
      if (wr_en_a) begin
        if (exp_a.size() == 0) begin
          check(1'b0, "R6", "unexpected write (A)", {wr_sel_a, wr_data_a}, 0);
        end else begin
          if (first_a) check(wr_sel_a, "R2", "first write target (A)", wr_sel_a, 1);
          check({wr_sel_a, wr_data_a} == exp_a[0], "R3 R4 R5",
                "write word (A)", {wr_sel_a, wr_data_a}, exp_a[0]);
          void'(exp_a.pop_front());
        end
        first_a = 1'b0;
      end
      if (busy_b) check(!wr_en_b, "R7", "write while busy (B)", wr_en_b, 0);
      if (wr_en_b) begin
        if (exp_b.size() == 0) begin
          check(1'b0, "R8", "unexpected write (B)", {wr_sel_b, wr_data_b}, 0);
        end else begin
          if (first_b) check(wr_sel_b, "R2", "first write target (B)", wr_sel_b, 1);
          check({wr_sel_b, wr_data_b} == exp_b[0], "R3 R4",
                "write word (B)", {wr_sel_b, wr_data_b}, exp_b[0]);
          void'(exp_b.pop_front());
        end
        first_b = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busy_a <= rand_busy & lfsr[0];
    busy_b <= rand_busy & lfsr[3];
  end

  task automatic pulse_a();
    @(posedge clk); #1 start_a = 1'b1;
    @(posedge clk); #1 start_a = 1'b0;
  endtask

  task automatic wait_flag(input bit b, input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (b ? err_b : done_a) begin seen = 1'b1; return; end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    bit seen;
    repeat (3) @(negedge clk);
    check(!wr_en_a && !done_a && !err_a, "R1", "outputs in reset (A)",
          {wr_en_a, done_a, err_a}, 0);
    check(!wr_en_b && !done_b && !err_b, "R1", "outputs in reset (B)",
          {wr_en_b, done_b, err_b}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!wr_en_a && !done_a && !err_a, "R1", "idle after reset",
          {wr_en_a, done_a, err_a}, 0);

    // First run with random busy and a start pulse mid-run (R10).
    build(1'b0); first_a = 1'b1; rand_busy = 1'b1;
    pulse_a();
    repeat (4) @(posedge clk);
    #1 start_a = 1'b1; @(posedge clk); #1 start_a = 1'b0;
    wait_flag(1'b0, 500, seen);
    check(seen, "R6", "done after terminator", seen, 1);
    check(exp_a.size() == 0, "R10", "all words written despite extra start",
          exp_a.size(), 0);
    check(!err_a, "R6", "no error on good image", err_a, 0);
    repeat (10) @(negedge clk);
    check(done_a, "R6", "done held", done_a, 1);

    // Restart from done (R9), with busy off.
    rand_busy = 1'b0;
    build(1'b0); first_a = 1'b1;
    pulse_a();
    @(negedge clk);
    check(!done_a, "R9", "done cleared by start", done_a, 0);
    wait_flag(1'b0, 500, seen);
    check(seen && exp_a.size() == 0, "R9", "second run complete",
          exp_a.size(), 0);
    check(exp_a.size() == 0, "R5", "empty segment wrote nothing", exp_a.size(), 0);

    // Overrun image (R8).
    rand_busy = 1'b1;
    build(1'b1); first_b = 1'b1;
    @(posedge clk); #1 start_b = 1'b1;
    @(posedge clk); #1 start_b = 1'b0;
    wait_flag(1'b1, 500, seen);
    check(seen, "R8", "error on overrun", seen, 1);
    check(!done_b, "R8", "done low on overrun", done_b, 0);
    repeat (10) @(negedge clk);
    check(err_b && !wr_en_b, "R8", "error held, no writes", {err_b, wr_en_b}, 2'b10);
    check(exp_b.size() == 0, "R8", "writes before overrun", exp_b.size(), 0);

    // Restart from error (R9).
    build(1'b1); first_b = 1'b1;
    @(posedge clk); #1 start_b = 1'b1;
    @(posedge clk); #1 start_b = 1'b0;
    @(negedge clk);
    check(!err_b, "R9", "error cleared by start", err_b, 0);
    wait_flag(1'b1, 500, seen);
    check(seen && exp_b.size() == 0, "R9", "overrun repeats", exp_b.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule